// File: doc/BRIEF.md
# Host Controller Interrupt Aggregator

This block collects the event pulses of a USB host controller into six sticky status flags and drives one level-sensitive interrupt line to the host CPU. Port change, frame-list rollover, host system error and the async-advance doorbell are recorded in the cycle after they occur. Transfer-complete and transfer-error events are held back by a pacing counter. The counter counts micro-frame ticks and releases those two events only once a programmable number of micro-frames has passed. Each flag reaches the interrupt line only when its enable bit is set.

Software reaches three 32-bit words through a simple write/read port: command, status and interrupt enable. The command word holds the Run bit, the doorbell request bit and the 8-bit pacing threshold. The status word holds the six flags and a Halted indication. A doorbell request stays pending until the schedule logic acknowledges it. At that point the request clears itself and the doorbell flag is raised.

Top module: `hc_irq_agg`

## Requirements
- R1: After reset the command word reads 0x0008_0000 (Run 0, doorbell 0, threshold 8), the status word reads 0x0000_1000 (only Halted, bit 12, set), the enable word reads 0, and `irq` is low.
- R2: A pulse on `ev_port`, `ev_roll` or `ev_hse` sets status bit 2, 3 or 4 respectively at the next clock edge, whatever the pacing counter holds.
- R3: A pulse on `ev_xfer` or `ev_err` is held pending and sets status bit 0 or 1 only on the `uf_tick` that expires the pacing counter. The counter expires on the Nth tick after a reload, where N is command bits 23:16. It reloads from that field when it expires and on every command write.
- R4: A threshold field of zero paces exactly like a threshold of one: every `uf_tick` expires the counter.
- R5: Status bits 5:0 are write-one-to-clear. A zero written to one of them leaves it unchanged. A flag that is set in the same cycle as a clear of that bit ends up set.
- R6: `irq` is high exactly when some status bit 5:0 is set while its enable bit (same position in the enable word, select 2) is set. It stays high until that flag is cleared or disabled. Enable bits 31:6 are ignored and read as 0.
- R7: Writing command bit 6 as 1 raises the doorbell request (read back in bit 6 and on `db_req`). Writing it as 0 does not withdraw the request. An `adv_ack` pulse while the request is pending clears bit 6 and sets status bit 5. An `adv_ack` with no request pending has no effect.
- R8: Writing Run (command bit 0) as 1 clears Halted (status bit 12) at the next edge. Writing Run as 0 while running leaves Halted low until the next `uf_tick`, after which Halted reads 1.
- R9: Reads return 0 in all reserved bit positions, and select 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ev_xfer | input | 1 | Transfer-complete event pulse |
| ev_err | input | 1 | Transfer-error event pulse |
| ev_port | input | 1 | Port-change event pulse |
| ev_roll | input | 1 | Frame-list rollover event pulse |
| ev_hse | input | 1 | Host system error event pulse |
| adv_ack | input | 1 | Schedule logic acknowledges the async-advance doorbell |
| uf_tick | input | 1 | One-cycle pulse at each micro-frame boundary |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write select: 0 command, 1 status, 2 enable |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Read select: 0 command, 1 status, 2 enable, 3 none |
| rd_data | output | 32 | Read data, combinational from rd_sel |
| irq | output | 1 | Level interrupt to the host CPU |
| run | output | 1 | Current Run bit |
| db_req | output | 1 | Pending doorbell request toward the schedule logic |

## Verification
Two situations can fall in the same clock cycle: a software write-one-to-clear of a status bit and a hardware event that sets the same bit. The bench provokes this by raising `ev_port` in the same cycle as a status write of 0x4, and expects bit 2 to read back as set. The second coincidence is the pacing counter releasing held transfer events on a tick. The bench places events several ticks ahead of an expiry and confirms that the flags stay clear until the exact expiring tick.

// File: rtl/hc_irq_pkg.sv
package hc_irq_pkg;

  localparam int unsigned NUM_SRC = 6;
  localparam int unsigned WORD_W  = 32;

  // status / enable bit positions
  localparam int unsigned B_XFER = 0;
  localparam int unsigned B_ERR  = 1;
  localparam int unsigned B_PORT = 2;
  localparam int unsigned B_ROLL = 3;
  localparam int unsigned B_HSE  = 4;
  localparam int unsigned B_DOOR = 5;
  localparam int unsigned B_HALT = 12;

  // command word fields
  localparam int unsigned C_RUN   = 0;
  localparam int unsigned C_DOOR  = 6;
  localparam int unsigned C_THR_L = 16;

  typedef enum logic [1:0] {
    SEL_CMD  = 2'd0,
    SEL_STS  = 2'd1,
    SEL_EN   = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/hc_irq_pacer.sv
module hc_irq_pacer #(
  parameter int unsigned THR_W   = 8,
  parameter int unsigned THR_RST = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             reload,
  input  logic [THR_W-1:0] thr,
  input  logic [1:0]       ev,
  output logic [1:0]       flush
);

  localparam logic [THR_W-1:0] CNT_RST = (THR_RST == 0) ? THR_W'(1) : THR_W'(THR_RST);

  logic [THR_W-1:0] cnt_q, cnt_d, eff_thr;
  logic [1:0]       pend_q, pend_d;
  logic             expire;

  always_comb begin
    eff_thr = (thr == '0) ? THR_W'(1) : thr;
    expire  = tick && (cnt_q <= THR_W'(1));
    cnt_d   = cnt_q;
    if (reload)
      cnt_d = eff_thr;
    else if (tick)
      cnt_d = expire ? eff_thr : cnt_q - THR_W'(1);
    flush  = expire ? (pend_q | ev) : 2'b00;
    pend_d = expire ? 2'b00 : (pend_q | ev);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= CNT_RST;
      pend_q <= 2'b00;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

endmodule

// File: rtl/hc_irq_cmd.sv
module hc_irq_cmd #(
  parameter int unsigned THR_W   = 8,
  parameter int unsigned THR_RST = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_cmd,
  input  logic             wd_run,
  input  logic             wd_door,
  input  logic [THR_W-1:0] wd_thr,
  input  logic             tick,
  input  logic             adv_ack,
  output logic             run,
  output logic             door,
  output logic [THR_W-1:0] thr,
  output logic             halted,
  output logic             door_done
);

  logic             run_q, run_d;
  logic             door_q, door_d;
  logic [THR_W-1:0] thr_q, thr_d;
  logic             halt_q, halt_d;
  logic             hpend_q, hpend_d;

  always_comb begin
    run_d     = run_q;
    thr_d     = thr_q;
    door_d    = door_q;
    halt_d    = halt_q;
    hpend_d   = hpend_q;
    door_done = adv_ack && door_q;

    if (door_done)
      door_d = 1'b0;
    if (hpend_q && tick) begin
      halt_d  = 1'b1;
      hpend_d = 1'b0;
    end

    if (wr_cmd) begin
      run_d = wd_run;
      thr_d = wd_thr;
      if (wd_door)
        door_d = 1'b1;
      if (wd_run) begin
        halt_d  = 1'b0;
        hpend_d = 1'b0;
      end else if (run_q) begin
        hpend_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      thr_q   <= THR_W'(THR_RST);
      door_q  <= 1'b0;
      halt_q  <= 1'b1;
      hpend_q <= 1'b0;
    end else begin
      run_q   <= run_d;
      thr_q   <= thr_d;
      door_q  <= door_d;
      halt_q  <= halt_d;
      hpend_q <= hpend_d;
    end
  end

  assign run    = run_q;
  assign door   = door_q;
  assign thr    = thr_q;
  assign halted = halt_q;

endmodule

// File: rtl/hc_irq_status.sv
module hc_irq_status #(
  parameter int unsigned NSRC = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_vec,
  input  logic            wr_sts,
  input  logic            wr_en,
  input  logic [NSRC-1:0] wd,
  output logic [NSRC-1:0] sts,
  output logic [NSRC-1:0] en,
  output logic            irq
);

  logic [NSRC-1:0] sts_q, sts_d;
  logic [NSRC-1:0] en_q, en_d;
  logic [NSRC-1:0] clr;

  always_comb begin
    clr  = wr_sts ? wd : '0;
    en_d = wr_en ? wd : en_q;
  end

  // per-bit: set wins over a same-cycle clear
  for (genvar i = 0; i < NSRC; i++) begin : g_flag
    always_comb sts_d[i] = set_vec[i] | (sts_q[i] & ~clr[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
      en_q  <= '0;
    end else begin
      sts_q <= sts_d;
      en_q  <= en_d;
    end
  end

  assign sts = sts_q;
  assign en  = en_q;
  assign irq = |(sts_q & en_q);

endmodule

// File: rtl/hc_irq_agg.sv
module hc_irq_agg
  import hc_irq_pkg::*;
#(
  parameter int unsigned THR_W   = 8,
  parameter int unsigned THR_RST = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ev_xfer,
  input  logic        ev_err,
  input  logic        ev_port,
  input  logic        ev_roll,
  input  logic        ev_hse,
  input  logic        adv_ack,
  input  logic        uf_tick,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic [31:0] wr_data,
  input  logic [1:0]  rd_sel,
  output logic [31:0] rd_data,
  output logic        irq,
  output logic        run,
  output logic        db_req
);

  localparam int unsigned THR_H = C_THR_L + THR_W - 1;

  logic                wr_cmd, wr_sts, wr_ien;
  logic [THR_W-1:0]    thr;
  logic                halted, door_done;
  logic [1:0]          flush;
  logic [NUM_SRC-1:0]  set_vec, sts, en;
  logic                unused_wd;

  always_comb begin
    wr_cmd = wr_en && (reg_sel_e'(wr_sel) == SEL_CMD);
    wr_sts = wr_en && (reg_sel_e'(wr_sel) == SEL_STS);
    wr_ien = wr_en && (reg_sel_e'(wr_sel) == SEL_EN);
  end

  assign unused_wd = ^{wr_data[WORD_W-1:THR_H+1], wr_data[C_THR_L-1:C_DOOR+1],
                       wr_data[C_DOOR-1:NUM_SRC]};

  hc_irq_cmd #(.THR_W(THR_W), .THR_RST(THR_RST)) u_cmd (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_cmd   (wr_cmd),
    .wd_run   (wr_data[C_RUN]),
    .wd_door  (wr_data[C_DOOR]),
    .wd_thr   (wr_data[THR_H:C_THR_L]),
    .tick     (uf_tick),
    .adv_ack  (adv_ack),
    .run      (run),
    .door     (db_req),
    .thr      (thr),
    .halted   (halted),
    .door_done(door_done)
  );

  hc_irq_pacer #(.THR_W(THR_W), .THR_RST(THR_RST)) u_pacer (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (uf_tick),
    .reload(wr_cmd),
    .thr   (wr_cmd ? wr_data[THR_H:C_THR_L] : thr),
    .ev    ({ev_err, ev_xfer}),
    .flush (flush)
  );

  always_comb begin
    set_vec         = '0;
    set_vec[B_XFER] = flush[0];
    set_vec[B_ERR]  = flush[1];
    set_vec[B_PORT] = ev_port;
    set_vec[B_ROLL] = ev_roll;
    set_vec[B_HSE]  = ev_hse;
    set_vec[B_DOOR] = door_done;
  end

  hc_irq_status #(.NSRC(NUM_SRC)) u_status (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_vec(set_vec),
    .wr_sts (wr_sts),
    .wr_en  (wr_ien),
    .wd     (wr_data[NUM_SRC-1:0]),
    .sts    (sts),
    .en     (en),
    .irq    (irq)
  );

  always_comb begin
    rd_data = '0;
    unique case (reg_sel_e'(rd_sel))
      SEL_CMD: begin
        rd_data[THR_H:C_THR_L] = thr;
        rd_data[C_DOOR]        = db_req;
        rd_data[C_RUN]         = run;
      end
      SEL_STS: begin
        rd_data[NUM_SRC-1:0] = sts;
        rd_data[B_HALT]      = halted;
      end
      SEL_EN:   rd_data[NUM_SRC-1:0] = en;
      SEL_NONE: rd_data = '0;
    endcase
  end

endmodule

// File: rtl/hc_irq_agg_chk.sv
module hc_irq_agg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ev_port,
  input logic        adv_ack,
  input logic        uf_tick,
  input logic        wr_en,
  input logic [1:0]  wr_sel,
  input logic [31:0] wr_data,
  input logic        irq,
  input logic        run,
  input logic        db_req,
  input logic [5:0]  sts,
  input logic        halted
);

  // R2: port change lands one edge after the pulse
  p_port_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_port |=> sts[2]);

  // R3: paced flags rise only on a micro-frame tick
  p_xfer_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts[0]) |-> $past(uf_tick));

  p_err_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts[1]) |-> $past(uf_tick));

  // R6: without any write the interrupt level cannot drop
  p_irq_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !wr_en) |=> irq);

  // R7: accepted acknowledge raises the doorbell flag
  p_door_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_ack && db_req) |=> sts[5]);

  p_door_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_ack && db_req && !(wr_en && wr_sel == 2'd0 && wr_data[6])) |=> !db_req);

  // R8: never running and halted at once; halting follows a tick
  p_run_halt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(run && halted));

  p_halt_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted) |-> $past(uf_tick));

endmodule

bind hc_irq_agg hc_irq_agg_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .ev_port(ev_port),
  .adv_ack(adv_ack),
  .uf_tick(uf_tick),
  .wr_en  (wr_en),
  .wr_sel (wr_sel),
  .wr_data(wr_data),
  .irq    (irq),
  .run    (run),
  .db_req (db_req),
  .sts    (sts),
  .halted (halted)
);

// File: tb/test_hc_irq_agg.sv
`timescale 1ns/1ps
module test_hc_irq_agg;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ev_xfer, ev_err, ev_port, ev_roll, ev_hse, adv_ack, uf_tick;
  logic        wr_en;
  logic [1:0]  wr_sel, rd_sel;
  logic [31:0] wr_data, rd_data;
  logic        irq, run, db_req;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  always #5 clk = ~clk;

  hc_irq_agg i_hc_irq_agg (
    .clk(clk), .rst_n(rst_n),
    .ev_xfer(ev_xfer), .ev_err(ev_err), .ev_port(ev_port), .ev_roll(ev_roll),
    .ev_hse(ev_hse), .adv_ack(adv_ack), .uf_tick(uf_tick),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data),
    .irq(irq), .run(run), .db_req(db_req)
  );

  // row: [15:13] events {hse,roll,port}, [12:7] enable, [6:1] status, [0] irq
  localparam int NROW = 6;
  localparam logic [15:0] TBL [NROW] = '{
    {3'b001, 6'h04, 6'h04, 1'b1},
    {3'b010, 6'h04, 6'h08, 1'b0},
    {3'b100, 6'h10, 6'h10, 1'b1},
    {3'b111, 6'h00, 6'h1C, 1'b0},
    {3'b110, 6'h3F, 6'h18, 1'b1},
    {3'b000, 6'h3F, 6'h00, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [1:0] sel);
    rd_sel = sel;
    return 32'h0;
  endfunction

  task automatic read(input logic [1:0] sel, output logic [31:0] v);
    rd_sel = sel;
    #1;
    v = rd_data;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic tick();
    @(negedge clk);
    uf_tick = 1'b1;
    @(negedge clk);
    uf_tick = 1'b0;
  endtask

  task automatic pulse(input logic [5:0] m);
    @(negedge clk);
    {adv_ack, ev_hse, ev_roll, ev_port, ev_err, ev_xfer} = m;
    @(negedge clk);
    {adv_ack, ev_hse, ev_roll, ev_port, ev_err, ev_xfer} = '0;
  endtask

  initial begin
    #(20000 * 10);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] dummy;
    rst_n = 1'b0;
    {ev_xfer, ev_err, ev_port, ev_roll, ev_hse, adv_ack, uf_tick} = '0;
    wr_en = 1'b0; wr_sel = '0; wr_data = '0; rd_sel = '0;
    dummy = rd(2'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    read(2'd0, v); check("R1 command", v, 32'h0008_0000);
    read(2'd1, v); check("R1 status", v, 32'h0000_1000);
    read(2'd2, v); check("R1 enable", v, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);

    // R2/R6 table of immediate events
    for (int i = 0; i < NROW; i++) begin
      wr(2'd1, 32'h3F);
      wr(2'd2, {26'b0, TBL[i][12:7]});
      pulse({1'b0, TBL[i][15:13], 2'b00});
      read(2'd1, v);
      check($sformatf("R2 row%0d status", i), {26'b0, v[5:0]}, {26'b0, TBL[i][6:1]});
      check($sformatf("R6 row%0d irq", i), {31'b0, irq}, {31'b0, TBL[i][0]});
    end

    // R6 enable upper bits ignored
    wr(2'd2, 32'hFFFF_FFFF);
    read(2'd2, v); check("R6 enable mask", v, 32'h3F);

    // R3 pacing with threshold 3
    wr(2'd1, 32'h3F);
    wr(2'd0, 32'h0003_0000);
    pulse(6'b000011);
    read(2'd1, v); check("R3 held before tick", {30'b0, v[1:0]}, 32'h0);
    tick(); tick();
    read(2'd1, v); check("R3 held after 2 ticks", {30'b0, v[1:0]}, 32'h0);
    check("R3 irq quiet", {31'b0, irq}, 32'h0);
    tick();
    read(2'd1, v); check("R3 released on 3rd tick", {30'b0, v[1:0]}, 32'h3);
    check("R3 irq", {31'b0, irq}, 32'h1);

    // R4 threshold zero behaves as one
    wr(2'd0, 32'h0);
    wr(2'd1, 32'h3F);
    pulse(6'b000001);
    read(2'd1, v); check("R4 held", {31'b0, v[0]}, 32'h0);
    tick();
    read(2'd1, v); check("R4 one tick", {31'b0, v[0]}, 32'h1);

    // R5 write-one-to-clear
    wr(2'd1, 32'h0);
    read(2'd1, v); check("R5 zero write keeps", {31'b0, v[0]}, 32'h1);
    wr(2'd1, 32'h1);
    read(2'd1, v); check("R5 one clears", {31'b0, v[0]}, 32'h0);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'd1; wr_data = 32'h4; ev_port = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; ev_port = 1'b0;
    read(2'd1, v); check("R5 set beats clear", {31'b0, v[2]}, 32'h1);

    // R7 doorbell
    wr(2'd1, 32'h3F);
    pulse(6'b100000);
    read(2'd1, v); check("R7 stray ack", {31'b0, v[5]}, 32'h0);
    wr(2'd0, 32'h40);
    read(2'd0, v); check("R7 request set", {31'b0, v[6]}, 32'h1);
    check("R7 db_req", {31'b0, db_req}, 32'h1);
    wr(2'd0, 32'h0);
    read(2'd0, v); check("R7 zero keeps request", {31'b0, v[6]}, 32'h1);
    pulse(6'b100000);
    read(2'd0, v); check("R7 self clear", {31'b0, v[6]}, 32'h0);
    read(2'd1, v); check("R7 flag", {31'b0, v[5]}, 32'h1);
    check("R7 irq", {31'b0, irq}, 32'h1);

    // R8 run / halted
    wr(2'd0, 32'h1);
    read(2'd1, v); check("R8 run clears halted", {31'b0, v[12]}, 32'h0);
    wr(2'd0, 32'h0);
    read(2'd1, v); check("R8 halted waits", {31'b0, v[12]}, 32'h0);
    tick();
    read(2'd1, v); check("R8 halted after tick", {31'b0, v[12]}, 32'h1);

    // R9 reserved bits and empty select
    read(2'd3, v); check("R9 select 3", v, 32'h0);
    wr(2'd0, 32'hFFFF_FFBE);
    read(2'd0, v); check("R9 command reserved", v, 32'h00FF_0000);
    read(2'd1, v); check("R9 status reserved", v & 32'hFFFF_EFC0, 32'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule